// File: doc/BRIEF.md
# Packed Calendar Clock with Alarm

This block keeps wall-clock time and calendar date for a chip that receives a one-per-second tick from a slow timebase. Time of day, weekday, day of month and month share one 32-bit word of binary fields. The year is a separate 16-bit word of four BCD digits. Each accepted tick advances the seconds. The carry then moves up through minutes, hours, weekday, day of month and month, and on into the BCD year. Day-of-month limits follow the month, and February follows the Gregorian leap rule.

Software sets the clock through two independent load ports, one for each word. A wrapper outside this block supplies the bus decode and interrupt status. Two match registers hold an alarm date word and an alarm year word. On the tick at which both new words equal their match values, the block emits a single-cycle alarm pulse for the wrapper to latch.

Top module: `calClock`

## Requirements
- R1: After reset the date word reads 0x021E0000 and the year word reads 0x2000. That is 2000-01-01 00:00:00 with the weekday at 7 (Saturday). The alarm output is low.
- R2: The date word fields are: seconds bits 5:0, minutes bits 11:6, hours bits 16:12, weekday bits 19:17, day of month bits 24:20 and month bits 28:25. An accepted tick adds one to seconds. Seconds 59 wraps to 0 and carries into minutes. Minutes 59 wraps to 0 and carries into hours. Hours 23 wraps to 0 and starts a new day.
- R3: At a new day, the day of month returns to 1 and the month advances when the day was the month's last. Months 4, 6, 9 and 11 end at 30, February ends at 28 or 29, and all other months end at 31. Otherwise the day of month increments.
- R4: February has 29 days when the year is divisible by 4 and not by 100, or is divisible by 400. The rule is evaluated on the BCD year word.
- R5: At every new day the weekday steps by one and wraps from 7 to 1, independently of the day of month.
- R6: Month 12 wraps to month 1 and increments the BCD year. The low byte holds the two low decimal digits. Carries cross every digit, for example 0x2099 becomes 0x2100 and 0x9999 becomes 0x0000.
- R7: A date load or a year load replaces only its own word, one cycle after the strobe. A tick in a cycle that carries any load is ignored.
- R8: The alarm pulse is high for exactly one cycle. It rises together with the advanced value, on a tick after which both the date word and the year word equal their match values. A load that produces matching values does not raise it.
- R9: The date match and year match registers are written by separate strobes. Writing a match register never raises the alarm by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle strobe, once per second |
| dateLoad | input | 1 | Load strobe for the date word |
| dateLoadVal | input | 32 | Date word value to load |
| yearLoad | input | 1 | Load strobe for the year word |
| yearLoadVal | input | 16 | BCD year value to load |
| matchDateWr | input | 1 | Write strobe for the date match register |
| matchDateVal | input | 32 | Date match value |
| matchYearWr | input | 1 | Write strobe for the year match register |
| matchYearVal | input | 16 | BCD year match value |
| dateNow | output | 32 | Current packed date word |
| yearNow | output | 16 | Current BCD year word |
| alarmPulse | output | 1 | One-cycle alarm pulse |

## Verification
The hardest situations to reach are the year-end carries, the leap-year decisions on century years, and the month-end limits. Reaching any of them from reset by ticking alone would take millions of ticks. The bench therefore loads both words to one second before each boundary, for example 23:59:59 on February 28 of 1900, 2000 and 2400, and on December 31 of 2099 and 9999. It then applies a single tick and compares the whole of both words.

// File: rtl/calPkg.sv
package calPkg;
  localparam int SEC_LSB  = 0;
  localparam int SEC_W    = 6;
  localparam int MIN_LSB  = 6;
  localparam int MIN_W    = 6;
  localparam int HOUR_LSB = 12;
  localparam int HOUR_W   = 5;
  localparam int WDAY_LSB = 17;
  localparam int WDAY_W   = 3;
  localparam int MDAY_LSB = 20;
  localparam int MDAY_W   = 5;
  localparam int MON_LSB  = 25;
  localparam int MON_W    = 4;
  localparam int DATE_W   = 32;

  // 2000-01-01, Saturday (7), 00:00:00
  localparam logic [DATE_W-1:0] DATE_RESET =
    (32'd1 << MON_LSB) | (32'd1 << MDAY_LSB) | (32'd7 << WDAY_LSB);

  typedef struct packed {
    logic loadDate;
    logic loadYear;
    logic advance;
    logic minStep;
    logic hourStep;
    logic dayStep;
    logic monStep;
    logic yearStep;
    logic wrMatchDate;
    logic wrMatchYear;
  } calStrobeT;
endpackage

// File: rtl/calCtrl.sv
module calCtrl
  import calPkg::*;
(
  input  logic              secTick,
  input  logic              dateLoad,
  input  logic              yearLoad,
  input  logic              matchDateWr,
  input  logic              matchYearWr,
  input  logic [SEC_W-1:0]  curSec,
  input  logic [MIN_W-1:0]  curMin,
  input  logic [HOUR_W-1:0] curHour,
  input  logic [MDAY_W-1:0] curMday,
  input  logic [MON_W-1:0]  curMon,
  input  logic [15:0]       curYearLow,
  output calStrobeT         stb
);
  logic [6:0]        loVal, hiVal;
  logic              leapYear;
  logic [MDAY_W-1:0] lastDay;

  always_comb begin
    loVal    = 7'(curYearLow[7:4])   * 7'd10 + 7'(curYearLow[3:0]);
    hiVal    = 7'(curYearLow[15:12]) * 7'd10 + 7'(curYearLow[11:8]);
    leapYear = (loVal != 7'd0) ? (loVal[1:0] == 2'b00) : (hiVal[1:0] == 2'b00);
  end

  always_comb begin
    unique case (curMon)
      4'd2:                      lastDay = leapYear ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   lastDay = 5'd30;
      default:                   lastDay = 5'd31;
    endcase
  end

  always_comb begin
    stb.loadDate    = dateLoad;
    stb.loadYear    = yearLoad;
    stb.wrMatchDate = matchDateWr;
    stb.wrMatchYear = matchYearWr;
    stb.advance     = secTick & ~dateLoad & ~yearLoad;
    stb.minStep     = stb.advance  & (curSec  == 6'd59);
    stb.hourStep    = stb.minStep  & (curMin  == 6'd59);
    stb.dayStep     = stb.hourStep & (curHour == 5'd23);
    stb.monStep     = stb.dayStep  & (curMday >= lastDay);
    stb.yearStep    = stb.monStep  & (curMon  >= 4'd12);
  end
endmodule

// File: rtl/calData.sv
module calData
  import calPkg::*;
#(
  parameter int DIGITS = 4,
  localparam int YEAR_W = 4 * DIGITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  calStrobeT         stb,
  input  logic [DATE_W-1:0] dateLoadVal,
  input  logic [YEAR_W-1:0] yearLoadVal,
  input  logic [DATE_W-1:0] matchDateVal,
  input  logic [YEAR_W-1:0] matchYearVal,
  output logic [DATE_W-1:0] dateQ,
  output logic [YEAR_W-1:0] yearQ,
  output logic              alarmPulse
);
  logic [DATE_W-1:0] matchDate, dateAdv, dateNext;
  logic [YEAR_W-1:0] matchYear, yearInc, yearNext;
  logic [DIGITS-1:0] carry;

  logic [SEC_W-1:0]  sec;
  logic [MIN_W-1:0]  min;
  logic [HOUR_W-1:0] hour;
  logic [WDAY_W-1:0] wday;
  logic [MDAY_W-1:0] mday;
  logic [MON_W-1:0]  mon;

  assign sec  = dateQ[SEC_LSB  +: SEC_W];
  assign min  = dateQ[MIN_LSB  +: MIN_W];
  assign hour = dateQ[HOUR_LSB +: HOUR_W];
  assign wday = dateQ[WDAY_LSB +: WDAY_W];
  assign mday = dateQ[MDAY_LSB +: MDAY_W];
  assign mon  = dateQ[MON_LSB  +: MON_W];

  // BCD ripple increment, one digit per generate step
  assign carry[0] = 1'b1;
  for (genvar g = 0; g < DIGITS; g++) begin : gDigit
    logic nine;
    assign nine = (yearQ[4*g +: 4] >= 4'd9);
    assign yearInc[4*g +: 4] = !carry[g] ? yearQ[4*g +: 4] :
                               nine      ? 4'd0 : yearQ[4*g +: 4] + 4'd1;
    if (g < DIGITS - 1) begin : gCarry
      assign carry[g+1] = carry[g] & nine;
    end
  end

  always_comb begin
    dateAdv = dateQ;
    dateAdv[SEC_LSB +: SEC_W] = stb.minStep ? '0 : sec + 6'd1;
    if (stb.minStep)
      dateAdv[MIN_LSB +: MIN_W] = stb.hourStep ? '0 : min + 6'd1;
    if (stb.hourStep)
      dateAdv[HOUR_LSB +: HOUR_W] = stb.dayStep ? '0 : hour + 5'd1;
    if (stb.dayStep) begin
      dateAdv[WDAY_LSB +: WDAY_W] = (wday >= 3'd7) ? 3'd1 : wday + 3'd1;
      dateAdv[MDAY_LSB +: MDAY_W] = stb.monStep ? 5'd1 : mday + 5'd1;
    end
    if (stb.monStep)
      dateAdv[MON_LSB +: MON_W] = stb.yearStep ? 4'd1 : mon + 4'd1;
  end

  always_comb begin
    dateNext = stb.loadDate ? dateLoadVal : stb.advance ? dateAdv : dateQ;
    yearNext = stb.loadYear ? yearLoadVal : stb.yearStep ? yearInc : yearQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dateQ      <= DATE_RESET;
      yearQ      <= YEAR_W'(16'h2000);
      matchDate  <= '0;
      matchYear  <= '0;
      alarmPulse <= 1'b0;
    end else begin
      dateQ      <= dateNext;
      yearQ      <= yearNext;
      alarmPulse <= stb.advance && (dateNext == matchDate) && (yearNext == matchYear);
      if (stb.wrMatchDate) matchDate <= matchDateVal;
      if (stb.wrMatchYear) matchYear <= matchYearVal;
    end
  end

  // R2
  sec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && !stb.minStep && !stb.loadDate) |=> (sec == 6'($past(sec) + 6'd1)));

  // R5
  wday_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dayStep && wday == 3'd7) |=> (wday == 3'd1));

  // R7
  date_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadDate |=> (dateQ == $past(dateLoadVal)));

  // R8
  alarm_eq_chk: assert property (@(posedge clk) disable iff (!rstN)
    alarmPulse |-> (dateQ == $past(matchDate) && yearQ == $past(matchYear)));

  // R8
  alarm_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    alarmPulse |-> $past(stb.advance));
endmodule

// File: rtl/calClock.sv
module calClock
  import calPkg::*;
#(
  parameter int DIGITS = 4,
  localparam int YEAR_W = 4 * DIGITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              dateLoad,
  input  logic [DATE_W-1:0] dateLoadVal,
  input  logic              yearLoad,
  input  logic [YEAR_W-1:0] yearLoadVal,
  input  logic              matchDateWr,
  input  logic [DATE_W-1:0] matchDateVal,
  input  logic              matchYearWr,
  input  logic [YEAR_W-1:0] matchYearVal,
  output logic [DATE_W-1:0] dateNow,
  output logic [YEAR_W-1:0] yearNow,
  output logic              alarmPulse
);
  calStrobeT stb;

  calCtrl u_ctrl (
    .secTick     (secTick),
    .dateLoad    (dateLoad),
    .yearLoad    (yearLoad),
    .matchDateWr (matchDateWr),
    .matchYearWr (matchYearWr),
    .curSec      (dateNow[SEC_LSB  +: SEC_W]),
    .curMin      (dateNow[MIN_LSB  +: MIN_W]),
    .curHour     (dateNow[HOUR_LSB +: HOUR_W]),
    .curMday     (dateNow[MDAY_LSB +: MDAY_W]),
    .curMon      (dateNow[MON_LSB  +: MON_W]),
    .curYearLow  (yearNow[15:0]),
    .stb         (stb)
  );

  calData #(.DIGITS(DIGITS)) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .dateLoadVal  (dateLoadVal),
    .yearLoadVal  (yearLoadVal),
    .matchDateVal (matchDateVal),
    .matchYearVal (matchYearVal),
    .dateQ        (dateNow),
    .yearQ        (yearNow),
    .alarmPulse   (alarmPulse)
  );
endmodule

// File: tb/calClock_tb.sv
`timescale 1ns/1ps
module calClock_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        secTick = 1'b0;
  logic        dateLoad = 1'b0;
  logic [31:0] dateLoadVal = '0;
  logic        yearLoad = 1'b0;
  logic [15:0] yearLoadVal = '0;
  logic        matchDateWr = 1'b0;
  logic [31:0] matchDateVal = '0;
  logic        matchYearWr = 1'b0;
  logic [15:0] matchYearVal = '0;
  logic [31:0] dateNow;
  logic [15:0] yearNow;
  logic        alarmPulse;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  calClock u_dut (
    .clk(clk), .rstN(rstN), .secTick(secTick),
    .dateLoad(dateLoad), .dateLoadVal(dateLoadVal),
    .yearLoad(yearLoad), .yearLoadVal(yearLoadVal),
    .matchDateWr(matchDateWr), .matchDateVal(matchDateVal),
    .matchYearWr(matchYearWr), .matchYearVal(matchYearVal),
    .dateNow(dateNow), .yearNow(yearNow), .alarmPulse(alarmPulse)
  );

  function automatic logic [31:0] pk(int mon, int mday, int wday, int hr, int mn, int sc);
    return {3'b000, 4'(mon), 5'(mday), 3'(wday), 5'(hr), 6'(mn), 6'(sc)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setNow(logic [31:0] d, logic [15:0] y);
    @(negedge clk);
    dateLoad = 1'b1; dateLoadVal = d; yearLoad = 1'b1; yearLoadVal = y;
    @(negedge clk);
    dateLoad = 1'b0; yearLoad = 1'b0;
  endtask

  task automatic tickOnce();
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic stepCase(string tag, logic [31:0] d, logic [15:0] y,
                          logic [31:0] ed, logic [15:0] ey);
    setNow(d, y);
    tickOnce();
    chk({tag, " date"}, dateNow, ed);
    chk({tag, " year"}, 32'(yearNow), 32'(ey));
  endtask

  task automatic testReset();
    chk("R1 date", dateNow, 32'h021E_0000);
    chk("R1 year", 32'(yearNow), 32'h2000);
    chk("R1 alarm", 32'(alarmPulse), 0);
  endtask

  task automatic testTimeCarry();
    stepCase("R2 sec", pk(3,5,2,12,34,10), 16'h2010, pk(3,5,2,12,34,11), 16'h2010);
    stepCase("R2 min", pk(3,5,2,12,34,59), 16'h2010, pk(3,5,2,12,35,0), 16'h2010);
    stepCase("R2 hour", pk(3,5,2,12,59,59), 16'h2010, pk(3,5,2,13,0,0), 16'h2010);
  endtask

  task automatic testMonthEnds();
    stepCase("R3 jan31", pk(1,31,7,23,59,59), 16'h2000, pk(2,1,1,0,0,0), 16'h2000);
    stepCase("R3 apr30", pk(4,30,3,23,59,59), 16'h2015, pk(5,1,4,0,0,0), 16'h2015);
    stepCase("R3 jun30", pk(6,30,3,23,59,59), 16'h2015, pk(7,1,4,0,0,0), 16'h2015);
    stepCase("R3 jul30", pk(7,30,5,23,59,59), 16'h2015, pk(7,31,6,0,0,0), 16'h2015);
    stepCase("R3 feb29", pk(2,29,5,23,59,59), 16'h2024, pk(3,1,6,0,0,0), 16'h2024);
  endtask

  task automatic testLeap();
    stepCase("R4 2001", pk(2,28,4,23,59,59), 16'h2001, pk(3,1,5,0,0,0), 16'h2001);
    stepCase("R4 2000", pk(2,28,2,23,59,59), 16'h2000, pk(2,29,3,0,0,0), 16'h2000);
    stepCase("R4 1900", pk(2,28,4,23,59,59), 16'h1900, pk(3,1,5,0,0,0), 16'h1900);
    stepCase("R4 2400", pk(2,28,2,23,59,59), 16'h2400, pk(2,29,3,0,0,0), 16'h2400);
    stepCase("R4 2024", pk(2,28,4,23,59,59), 16'h2024, pk(2,29,5,0,0,0), 16'h2024);
  endtask

  task automatic testWeekday();
    stepCase("R5 wrap", pk(5,10,7,23,59,59), 16'h2020, pk(5,11,1,0,0,0), 16'h2020);
    stepCase("R5 step", pk(5,10,3,23,59,59), 16'h2020, pk(5,11,4,0,0,0), 16'h2020);
  endtask

  task automatic testYear();
    stepCase("R6 2019", pk(12,31,3,23,59,59), 16'h2019, pk(1,1,4,0,0,0), 16'h2020);
    stepCase("R6 2099", pk(12,31,5,23,59,59), 16'h2099, pk(1,1,6,0,0,0), 16'h2100);
    stepCase("R6 9999", pk(12,31,6,23,59,59), 16'h9999, pk(1,1,7,0,0,0), 16'h0000);
  endtask

  task automatic testLoads();
    setNow(pk(8,8,1,8,8,8), 16'h2008);
    @(negedge clk);
    yearLoad = 1'b1; yearLoadVal = 16'h2031;
    @(negedge clk);
    yearLoad = 1'b0;
    chk("R7 year only", 32'(yearNow), 32'h2031);
    chk("R7 date kept", dateNow, pk(8,8,1,8,8,8));
    @(negedge clk);
    dateLoad = 1'b1; dateLoadVal = pk(9,1,2,7,6,5);
    @(negedge clk);
    dateLoad = 1'b0;
    chk("R7 date only", dateNow, pk(9,1,2,7,6,5));
    chk("R7 year kept", 32'(yearNow), 32'h2031);
    @(negedge clk);
    dateLoad = 1'b1; dateLoadVal = pk(9,1,2,7,6,20); secTick = 1'b1;
    @(negedge clk);
    dateLoad = 1'b0; secTick = 1'b0;
    chk("R7 tick with date load", dateNow, pk(9,1,2,7,6,20));
    @(negedge clk);
    yearLoad = 1'b1; yearLoadVal = 16'h2032; secTick = 1'b1;
    @(negedge clk);
    yearLoad = 1'b0; secTick = 1'b0;
    chk("R7 tick with year load", dateNow, pk(9,1,2,7,6,20));
  endtask

  task automatic testAlarm();
    @(negedge clk);
    matchDateWr = 1'b1; matchDateVal = pk(3,5,6,10,0,0);
    matchYearWr = 1'b1; matchYearVal = 16'h2010;
    @(negedge clk);
    matchDateWr = 1'b0; matchYearWr = 1'b0;
    chk("R9 match write no pulse", 32'(alarmPulse), 0);
    setNow(pk(3,5,6,9,59,59), 16'h2010);
    chk("R8 before", 32'(alarmPulse), 0);
    tickOnce();
    chk("R8 pulse", 32'(alarmPulse), 1);
    @(negedge clk);
    chk("R8 one cycle", 32'(alarmPulse), 0);
    tickOnce();
    chk("R8 next tick", 32'(alarmPulse), 0);
    setNow(pk(3,5,6,10,0,0), 16'h2010);
    chk("R8 load match no pulse", 32'(alarmPulse), 0);
    @(negedge clk);
    chk("R8 load match stays low", 32'(alarmPulse), 0);
    setNow(pk(3,5,6,9,59,59), 16'h2011);
    tickOnce();
    chk("R8 year mismatch", 32'(alarmPulse), 0);
    setNow(pk(3,5,6,9,59,59), 16'h2010);
    @(negedge clk);
    matchYearWr = 1'b1; matchYearVal = 16'h2012;
    @(negedge clk);
    matchYearWr = 1'b0;
    tickOnce();
    chk("R9 year match rewritten", 32'(alarmPulse), 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTimeCarry();
    testMonthEnds();
    testLeap();
    testWeekday();
    testYear();
    testLoads();
    testAlarm();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule